// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This block chooses which of three free-running clocks drives the system clock: a fast primary clock, a slow secondary oscillator, or an internal oscillator. Software writes a 2-bit selection into a pending register. That selection takes effect only when a power-managed-mode entry strobe arrives. Until then, the current source keeps running.

A switch is made without runt pulses. The block first closes the old source's gate on a low phase of that clock. It then waits until the new source reports ready. The new source's gate opens only after a settling count of that clock's own edges. In between, the output stays low. Three status flags report which source is driving. When none is set, the block is between sources, or the selected source is not yet ready.

The control state machine runs on an always-on control clock and has four states:
- `S_RUN`: a source is connected and stable.
- `S_CLOSE`: the old gate has been released; the block waits for the close acknowledge.
- `S_WAIT_RDY`: the block waits for the new source's ready input.
- `S_OPEN`: the new gate has been requested; the block waits for the open acknowledge.

The transitions are:
- `S_RUN` goes to `S_CLOSE` on an entry strobe whose decoded selection differs from the active source.
- `S_CLOSE` goes to `S_WAIT_RDY` once the old gate reads closed.
- `S_WAIT_RDY` goes to `S_OPEN` once the new source is ready.
- `S_OPEN` goes to `S_RUN` once the new gate reads open. The active source is updated at this point.

Reset enters `S_WAIT_RDY` with the primary clock as the target.

Top module: `sysclk_switch`

## Requirements
- R1: The selection code picks the source: 2'b00 primary, 2'b01 secondary, 2'b10 and 2'b11 internal. After a completed switch, the system clock has the period of the selected source.
- R2: A selection write alone changes neither the driving source nor the status flags. Only an entry strobe (`pm_entry`) seen in `S_RUN` applies the pending selection.
- R3: Reset clears the pending selection to 2'b00. The primary clock then drives once `pri_ready` is high, and a later entry strobe with no new write keeps the primary clock.
- R4: During a switch, the system clock stays low for at least 8 full periods of the new source before its first pulse. The gate opens only after 8 edges of the new clock, counted after synchronization.
- R5: No high or low phase of the system clock is shorter than the shorter half-period of the clocks involved. At most one source gate is open at any time.
- R6: A write whose bit 0 is 1 while `sec_en` is low is discarded. The pending selection keeps its previous value.
- R7: The new source is not connected until its ready input is high. Meanwhile the system clock shows no edges.
- R8: The flags work as follows:
  - `stat_pri` is high when the primary clock drives and `pri_ready` is high.
  - `stat_sec` is high when the secondary clock drives and `sec_ready` is high.
  - `stat_int` is high when the internal clock drives and `int_stable` is high.
  - All three flags are low while a switch is in progress.
- R9: An entry strobe whose decoded selection equals the active source causes no switch and no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Always-on control clock for the state machine |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pri | input | 1 | Primary source clock |
| clk_sec | input | 1 | Secondary low-frequency oscillator clock |
| clk_int | input | 1 | Internal oscillator clock |
| sel_wr | input | 1 | Write strobe for the pending selection |
| sel_data | input | 2 | Selection code to write |
| sec_en | input | 1 | Secondary oscillator enabled |
| pm_entry | input | 1 | Power-managed-mode entry strobe, one control cycle |
| pri_ready | input | 1 | Primary start-up time-out elapsed |
| sec_ready | input | 1 | Secondary oscillator running |
| int_stable | input | 1 | Internal oscillator stable |
| sys_clk | output | 1 | Switched system clock |
| stat_pri | output | 1 | Primary clock is driving |
| stat_sec | output | 1 | Secondary clock is driving |
| stat_int | output | 1 | Internal clock is driving |

## Verification
Some properties are checked by the assertions on every cycle:
- At most one gate is open at a time.
- A gate is open only while its request is held and its settling count is complete.
- Rejected writes leave the pending selection unchanged.
- Nothing moves in `S_RUN` without an entry strobe.
- A gate opens only after the ready input was seen.
- A flag is raised only for a requested source.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the period of the output after each switch;
- the length of the silent gap before the new clock;
- the shortest output phase across a series of random switches;
- the silent wait for a late ready;
- the return to the primary clock after reset.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        S_RUN      = 2'd0,
        S_CLOSE    = 2'd1,
        S_WAIT_RDY = 2'd2,
        S_OPEN     = 2'd3
    } sw_state_e;

    // Bit 1 picks the internal block, otherwise bit 0 picks the secondary.
    function automatic src_e decode_sel(input logic [1:0] code);
        if (code[1])
            return SRC_INT;
        else if (code[0])
            return SRC_SEC;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
    parameter int SETTLE = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    output logic gclk,
    output logic gate
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(SETTLE);

    logic          req_s;
    logic [CW-1:0] cnt_q;
    logic          gate_q;

    clksw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    // Settling counter: counts edges of the incoming clock while requested.
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!req_s)
            cnt_q <= '0;
        else if (cnt_q != CNT_DONE)
            cnt_q <= cnt_q + 1'b1;
    end

    // Gate changes only while the source clock is low.
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= req_s && (cnt_q == CNT_DONE);
    end

    assign gclk = clk_src & gate_q;
    assign gate = gate_q;

    // R4: an open gate implies a held request and a finished settling count
    a_r4_open_after_settle: assert property (
        @(posedge clk_src) disable iff (!rst_n)
        gate_q |-> (req_s && cnt_q == CNT_DONE)
    );

    // R4: the counter never runs past its limit
    a_r4_count_bounded: assert property (
        @(posedge clk_src) disable iff (!rst_n)
        cnt_q <= CNT_DONE
    );
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_ctl,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [1:0]         sel_data,
    input  logic               sec_en,
    input  logic               pm_entry,
    input  logic [NUM_SRC-1:0] src_rdy,
    input  logic [NUM_SRC-1:0] gate_ack,
    output logic [NUM_SRC-1:0] gate_req,
    output logic [NUM_SRC-1:0] stat
);
    sw_state_e          state_q, state_d;
    logic [1:0]         pend_q;
    src_e               act_q, tgt_q, want;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] ack_s;
    logic               wr_ok, go_sw;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
        clksw_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
            .clk   (clk_ctl),
            .rst_n (rst_n),
            .d     (gate_ack[g]),
            .q     (ack_s[g])
        );
    end

    assign wr_ok = sel_wr && !(sel_data[0] && !sec_en);
    assign want  = decode_sel(pend_q);
    assign go_sw = pm_entry && (want != act_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:      if (go_sw)             state_d = S_CLOSE;
            S_CLOSE:    if (!ack_s[act_q])     state_d = S_WAIT_RDY;
            S_WAIT_RDY: if (src_rdy[tgt_q])    state_d = S_OPEN;
            S_OPEN:     if (ack_s[tgt_q])      state_d = S_RUN;
            default:                           state_d = S_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk_ctl or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_WAIT_RDY;
        else
            state_q <= state_d;
    end

    // Selection register, gate requests and active source
    always_ff @(posedge clk_ctl or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 2'b00;
            act_q  <= SRC_PRI;
            tgt_q  <= SRC_PRI;
            en_q   <= '0;
        end else begin
            if (wr_ok)
                pend_q <= sel_data;
            unique case (state_q)
                S_RUN: if (go_sw) begin
                    tgt_q       <= want;
                    en_q[act_q] <= 1'b0;
                end
                S_CLOSE: ;
                S_WAIT_RDY: if (src_rdy[tgt_q])
                    en_q[tgt_q] <= 1'b1;
                S_OPEN: if (ack_s[tgt_q])
                    act_q <= tgt_q;
                default: ;
            endcase
        end
    end

    // Status outputs
    always_comb begin
        stat = '0;
        if (state_q == S_RUN && ack_s[act_q] && src_rdy[act_q])
            stat[act_q] = 1'b1;
    end

    assign gate_req = en_q;

    // R6: a rejected write leaves the pending selection untouched
    a_r6_reject_sec_write: assert property (
        @(posedge clk_ctl) disable iff (!rst_n)
        (sel_wr && sel_data[0] && !sec_en) |=> $stable(pend_q)
    );

    // R2: without an entry strobe nothing moves while running
    a_r2_no_switch_without_entry: assert property (
        @(posedge clk_ctl) disable iff (!rst_n)
        (state_q == S_RUN && !pm_entry) |=> ($stable(en_q) && $stable(act_q))
    );

    // R7: a gate request is raised only after the ready input was seen
    a_r7_open_needs_ready: assert property (
        @(posedge clk_ctl) disable iff (!rst_n)
        (state_q == S_OPEN && $past(state_q) == S_WAIT_RDY) |-> $past(src_rdy[tgt_q])
    );

    // R8: a flag is only ever raised for a requested source
    a_r8_flag_needs_req: assert property (
        @(posedge clk_ctl) disable iff (!rst_n)
        (stat & ~en_q) == '0
    );

    // R5: at most one gate is requested
    a_r5_one_request: assert property (
        @(posedge clk_ctl) disable iff (!rst_n)
        $onehot0(en_q)
    );
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import clksw_pkg::*;
#(
    parameter int SETTLE      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_ctl,
    input  logic       rst_n,
    input  logic       clk_pri,
    input  logic       clk_sec,
    input  logic       clk_int,
    input  logic       sel_wr,
    input  logic [1:0] sel_data,
    input  logic       sec_en,
    input  logic       pm_entry,
    input  logic       pri_ready,
    input  logic       sec_ready,
    input  logic       int_stable,
    output logic       sys_clk,
    output logic       stat_pri,
    output logic       stat_sec,
    output logic       stat_int
);
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] src_rdy;
    logic [NUM_SRC-1:0] gate_req;
    logic [NUM_SRC-1:0] gate_vec;
    logic [NUM_SRC-1:0] gclk_vec;
    logic [NUM_SRC-1:0] stat;

    assign src_clk = {clk_int, clk_sec, clk_pri};
    assign src_rdy = {int_stable, sec_ready, pri_ready};

    clksw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk_ctl  (clk_ctl),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_data (sel_data),
        .sec_en   (sec_en),
        .pm_entry (pm_entry),
        .src_rdy  (src_rdy),
        .gate_ack (gate_vec),
        .gate_req (gate_req),
        .stat     (stat)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        clksw_gate #(.SETTLE(SETTLE), .SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_src (src_clk[g]),
            .rst_n   (rst_n),
            .req     (gate_req[g]),
            .gclk    (gclk_vec[g]),
            .gate    (gate_vec[g])
        );
    end

    assign sys_clk  = |gclk_vec;
    assign stat_pri = stat[SRC_PRI];
    assign stat_sec = stat[SRC_SEC];
    assign stat_int = stat[SRC_INT];

    // R5: gates in separate clock domains are never open together
    a_r5_one_gate_open: assert property (
        @(posedge clk_ctl) disable iff (!rst_n)
        $onehot0(gate_vec)
    );
endmodule

// File: tb/sysclk_switch_tb_top.sv
`timescale 1ns/1ps
module sysclk_switch_tb_top;
    localparam real T_CTL = 20.0;
    localparam real T_PRI = 14.0;
    localparam real T_SEC = 90.0;
    localparam real T_INT = 34.0;
    localparam real MIN_HALF = 7.0;

    logic clk_ctl = 0, clk_pri = 0, clk_sec = 0, clk_int = 0;
    logic rst_n = 0;
    logic sel_wr = 0, sec_en = 0, pm_entry = 0;
    logic [1:0] sel_data = 2'b00;
    logic pri_ready = 1, sec_ready = 1, int_stable = 1;
    logic sys_clk, stat_pri, stat_sec, stat_int;

    int n_chk = 0, n_bad = 0;
    int viol = 0, edge_cnt = 0;
    realtime last_t = 0;
    real max_low = 0.0;

    always #(T_CTL/2) clk_ctl = ~clk_ctl;
    always #(T_PRI/2) clk_pri = ~clk_pri;
    always #(T_SEC/2) clk_sec = ~clk_sec;
    always #(T_INT/2) clk_int = ~clk_int;

    sysclk_switch dut_i (
        .clk_ctl(clk_ctl), .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec),
        .clk_int(clk_int), .sel_wr(sel_wr), .sel_data(sel_data), .sec_en(sec_en),
        .pm_entry(pm_entry), .pri_ready(pri_ready), .sec_ready(sec_ready),
        .int_stable(int_stable), .sys_clk(sys_clk), .stat_pri(stat_pri),
        .stat_sec(stat_sec), .stat_int(stat_int)
    );

    // Output phase monitor
    always @(sys_clk) begin
        real dur;
        dur = $realtime - last_t;
        if (rst_n === 1'b1) begin
            if (dur < MIN_HALF - 0.01) viol++;
            if (sys_clk === 1'b1 && dur > max_low) max_low = dur;
            edge_cnt++;
        end
        last_t = $realtime;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] code);
        @(negedge clk_ctl); sel_wr = 1; sel_data = code;
        @(negedge clk_ctl); sel_wr = 0;
    endtask

    task automatic entry();
        @(negedge clk_ctl); pm_entry = 1;
        @(negedge clk_ctl); pm_entry = 0;
    endtask

    task automatic wait_flags(input logic [2:0] want, output bit ok);
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk_ctl);
            if ({stat_int, stat_sec, stat_pri} == want) begin ok = 1; break; end
        end
    endtask

    task automatic period(output real p);
        realtime t0;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); p = $realtime - t0;
    endtask

    task automatic expect_src(input string req, input logic [2:0] flags, input real tp);
        bit ok; real p;
        wait_flags(flags, ok);
        check(ok, req, "status flags reached", real'(ok), 1.0);
        period(p);
        check(p > tp - 0.5 && p < tp + 0.5, req, "output period", p, tp);
    endtask

    task automatic do_reset();
        @(negedge clk_ctl); rst_n = 0;
        repeat (3) @(negedge clk_ctl);
        rst_n = 1;
    endtask

    // R3: reset state and primary start
    task automatic t_reset();
        check({stat_int, stat_sec, stat_pri} == 3'b000, "R3", "flags in reset", 0.0, 0.0);
        do_reset();
        expect_src("R3", 3'b001, T_PRI);
        check({stat_int, stat_sec, stat_pri} == 3'b001, "R8", "only primary flag", real'(stat_pri), 1.0);
    endtask

    // R2: write without entry changes nothing
    task automatic t_hold();
        real p; int e0;
        write_sel(2'b10);
        repeat (200) @(negedge clk_ctl);
        check(stat_pri && !stat_int, "R2", "primary still flagged", real'(stat_pri), 1.0);
        period(p);
        check(p > T_PRI - 0.5 && p < T_PRI + 0.5, "R2", "period unchanged", p, T_PRI);
        e0 = edge_cnt;
        max_low = 0;
        repeat (20) @(negedge clk_ctl);
        check(max_low < 2.0 * T_PRI, "R2", "no pause", max_low, T_PRI);
    endtask

    // R1/R4: switch to internal, gap at least 8 new periods
    task automatic t_to_int();
        max_low = 0;
        entry();
        expect_src("R1", 3'b100, T_INT);
        check(max_low >= 8.0 * T_INT, "R4", "silent gap before internal", max_low, 8.0 * T_INT);
    endtask

    // R6: secondary request without enable is dropped
    task automatic t_reject();
        real p;
        sec_en = 0;
        write_sel(2'b01);
        max_low = 0;
        entry();
        repeat (300) @(negedge clk_ctl);
        check(stat_int && !stat_sec, "R6", "internal kept", real'(stat_int), 1.0);
        period(p);
        check(p > T_INT - 0.5 && p < T_INT + 0.5, "R6", "period still internal", p, T_INT);
    endtask

    // R1/R4: enabled secondary
    task automatic t_to_sec();
        sec_en = 1;
        write_sel(2'b01);
        max_low = 0;
        entry();
        expect_src("R1", 3'b010, T_SEC);
        check(max_low >= 8.0 * T_SEC, "R4", "silent gap before secondary", max_low, 8.0 * T_SEC);
    endtask

    // R7/R8: late ready keeps the output silent and all flags clear
    task automatic t_late_ready();
        int e0;
        pri_ready = 0;
        write_sel(2'b00);
        entry();
        repeat (60) @(negedge clk_ctl);
        e0 = edge_cnt;
        repeat (300) @(negedge clk_ctl);
        check(edge_cnt == e0, "R7", "edges while waiting", real'(edge_cnt - e0), 0.0);
        check({stat_int, stat_sec, stat_pri} == 3'b000, "R8", "flags during switch",
              real'({stat_int, stat_sec, stat_pri}), 0.0);
        pri_ready = 1;
        expect_src("R7", 3'b001, T_PRI);
    endtask

    // R9: entry with unchanged selection
    task automatic t_same();
        write_sel(2'b00);
        max_low = 0;
        entry();
        repeat (100) @(negedge clk_ctl);
        check(stat_pri, "R9", "primary still flagged", real'(stat_pri), 1.0);
        check(max_low < 2.0 * T_PRI, "R9", "no pause on same source", max_low, T_PRI);
    endtask

    // R3: reset drops a pending choice
    task automatic t_reset_pending();
        write_sel(2'b10);
        entry();
        expect_src("R1", 3'b100, T_INT);
        write_sel(2'b01);
        do_reset();
        expect_src("R3", 3'b001, T_PRI);
        entry();
        repeat (300) @(negedge clk_ctl);
        check(stat_pri, "R3", "pending cleared to primary", real'(stat_pri), 1.0);
    endtask

    // R1/R5: random sequence of switches
    task automatic t_random();
        logic [1:0] code; logic [2:0] fl; real tp;
        sec_en = 1;
        for (int i = 0; i < 8; i++) begin
            code = 2'($urandom_range(0, 3));
            if (code[1]) begin fl = 3'b100; tp = T_INT; end
            else if (code[0]) begin fl = 3'b010; tp = T_SEC; end
            else begin fl = 3'b001; tp = T_PRI; end
            write_sel(code);
            entry();
            repeat (3) @(negedge clk_ctl);
            expect_src("R1", fl, tp);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk_ctl);
        t_reset();
        t_hold();
        t_to_int();
        t_reject();
        t_to_sec();
        t_late_ready();
        t_same();
        t_reset_pending();
        t_random();
        check(viol == 0, "R5", "short output phases", real'(viol), 0.0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule